// File: doc/BRIEF.md
# Serial Synthesizer Control Register Bank

This block is the write-only configuration front end of an integer-N frequency synthesizer. A host shifts 24-bit words in over three plain wires: a serial clock, a serial data line and a load strobe. When the load strobe rises, the two lowest bits of the shifted word pick one of three holding registers, and the word is copied there. The block then breaks the three holding registers into the fields the synthesizer core uses: the reference divide value, the swallow and main counter values, the prescaler modulus select, the lock-detect precision, the phase-detector sense, and the power, counter-hold and charge-pump controls.

All three serial wires are sampled in the block's own clock domain through a synchronizer. Their rising edges are found by comparing the current sample with the one before. An active-high chip-enable input acts at once, with no clock delay, and overrides the software power-down bit. A three-bit field in the function register selects which signal reaches a single monitor output. The candidates are the lock indicators, the divider taps, the serial shift chain and two constants. There is no data stream and no back-pressure: every pin is a plain level.

Top module: `synctl_top`

## Requirements
- R1: On each rising edge of `ser_clk`, the 24-bit shift chain moves up one place and takes `ser_data` into bit 0. After 24 edges, the first bit sent sits in bit 23.
- R2: A rising edge of `ser_load` copies the shift chain into one register, chosen by chain bits [1:0]: 2'b00 reference, 2'b01 counter, 2'b10 function. The decoded outputs reflect the new word no more than 3 `clk` edges after the strobe edge is sampled.
- R3: Reference register: bits [15:2] drive `r_div` and bits [17:16] drive `bl_code`.
- R4: Counter register: bits [7:2] drive `a_cnt`, bits [20:8] drive `b_cnt`, and bit 21 drives `ld_fine` (1 selects the tighter lock window).
- R5: Function register: bit 2 is counter reset, bit 3 is software power-down, bits [6:4] drive `mux_sel`, bit 7 drives `pd_neg`, bit 8 is the charge-pump three-state request, and bits [23:22] drive `psc_sel`.
- R6: Monitor selection by `mux_sel`, giving `mon_out`/`mon_oe`: 000 gives 0/0 (released); 001 gives `lock_dig` gated low during power-down; 010 gives `ndiv_tap`; 011 gives constant 1; 100 gives `rdiv_tap`; 101 gives `lock_ana`; 110 gives shift-chain bit 23; 111 gives constant 0. `mon_oe` is 1 for every code except 000.
- R7: While `chip_en` is low, `pwr_down`, `cp_hiz` and `cnt_hold` are all 1 in the same cycle, whatever the software power-down bit holds.
- R8: Shifting and loading continue while `chip_en` is low. Register contents stay unchanged when `chip_en` toggles.
- R9: A load whose bits [1:0] are 2'b11 changes none of the three registers.
- R10: After reset every register reads zero. With `chip_en` high, every decoded output and `mon_oe` are then 0.
- R11: `cp_hiz` is 1 when the three-state bit, counter reset or power-down is active. `cnt_hold` is 1 when counter reset or power-down is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; rising edge commits the word |
| chip_en | input | 1 | Chip enable; low forces power-down |
| lock_dig | input | 1 | Digital lock indicator to monitor |
| lock_ana | input | 1 | Analog lock indicator to monitor |
| ndiv_tap | input | 1 | Feedback divider output to monitor |
| rdiv_tap | input | 1 | Reference divider output to monitor |
| r_div | output | 14 | Reference divide value |
| bl_code | output | 2 | Anti-backlash width code |
| a_cnt | output | 6 | Swallow counter value |
| b_cnt | output | 13 | Main counter value |
| ld_fine | output | 1 | Lock-detect precision select |
| psc_sel | output | 2 | Prescaler modulus select |
| pd_neg | output | 1 | Phase detector negative sense |
| mux_sel | output | 3 | Monitor select field |
| pwr_down | output | 1 | Effective power-down |
| cnt_hold | output | 1 | Counters held at load state |
| cp_hiz | output | 1 | Charge pump three-stated |
| mon_out | output | 1 | Monitor output value |
| mon_oe | output | 1 | Monitor output drive enable |

## Verification
Two things can land in the same window: a function-register load and a low chip enable. The bench drops `chip_en`, then loads a function word with software power-down cleared and a new monitor code. It checks that the new monitor code takes effect at once while `pwr_down`, `cp_hiz` and `cnt_hold` stay asserted. The digital lock path is also held low under that power-down. After `chip_en` rises again, the forced controls must clear and every field loaded during the low period must still read back.

// File: rtl/synctl_pkg.sv
package synctl_pkg;
  localparam int WORD_W = 24;
  localparam int DST_W  = 2;
  localparam int NUM_DST = 3;

  typedef enum logic [1:0] {
    DST_REF  = 2'b00,
    DST_CNT  = 2'b01,
    DST_FUNC = 2'b10,
    DST_NONE = 2'b11
  } dst_e;

  typedef enum logic [2:0] {
    MX_HIZ   = 3'b000,
    MX_LOCKD = 3'b001,
    MX_NDIV  = 3'b010,
    MX_HIGH  = 3'b011,
    MX_RDIV  = 3'b100,
    MX_LOCKA = 3'b101,
    MX_SDO   = 3'b110,
    MX_LOW   = 3'b111
  } mon_e;

  // reference register
  localparam int RDIV_LO = 2;
  localparam int RDIV_W  = 14;
  localparam int BL_LO   = 16;
  localparam int BL_W    = 2;
  // counter register
  localparam int ACNT_LO = 2;
  localparam int ACNT_W  = 6;
  localparam int BCNT_LO = 8;
  localparam int BCNT_W  = 13;
  localparam int LDF_BIT = 21;
  // function register
  localparam int CRST_BIT = 2;
  localparam int SWPD_BIT = 3;
  localparam int MUX_LO   = 4;
  localparam int MUX_W    = 3;
  localparam int POL_BIT  = 7;
  localparam int TRI_BIT  = 8;
  localparam int PSC_LO   = 22;
  localparam int PSC_W    = 2;
endpackage

// File: rtl/synctl_sync_edge.sv
module synctl_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= pipe[STAGES-1];

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/synctl_shifter.sv
module synctl_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};

  // R1: older bits move toward the MSB, the new bit enters at bit 0
  p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(bit_in)) &&
                 (word[WORD_W-1] == $past(word[WORD_W-2])));
endmodule

// File: rtl/synctl_latch_bank.sv
module synctl_latch_bank
  import synctl_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] ref_q,
  output logic [WORD_W-1:0] cnt_q,
  output logic [WORD_W-1:0] fn_q
);
  logic [WORD_W-1:0] bank [NUM_DST];

  genvar d;
  generate
    for (d = 0; d < NUM_DST; d++) begin : g_dst
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) bank[d] <= '0;
        else if (load_en && (word[DST_W-1:0] == DST_W'(d))) bank[d] <= word;
    end
  endgenerate

  assign ref_q = bank[DST_REF];
  assign cnt_q = bank[DST_CNT];
  assign fn_q  = bank[DST_FUNC];

  // R9: the unused destination code leaves every register alone
  p_skip_code3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && word[1:0] == DST_NONE) |=>
      ($stable(ref_q) && $stable(cnt_q) && $stable(fn_q)));

  // R2: a load toward the counter register lands there and nowhere else
  p_route_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && word[1:0] == DST_CNT) |=>
      (cnt_q == $past(word)) && $stable(ref_q) && $stable(fn_q));
endmodule

// File: rtl/synctl_outmux.sv
module synctl_outmux
  import synctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       pd_eff,
  input  logic       lock_dig,
  input  logic       lock_ana,
  input  logic       ndiv_tap,
  input  logic       rdiv_tap,
  input  logic       sdo,
  output logic       mon_out,
  output logic       mon_oe
);
  always_comb begin
    mon_oe  = 1'b1;
    mon_out = 1'b0;
    unique case (mon_e'(sel))
      MX_HIZ:   mon_oe  = 1'b0;
      MX_LOCKD: mon_out = lock_dig & ~pd_eff;
      MX_NDIV:  mon_out = ndiv_tap;
      MX_HIGH:  mon_out = 1'b1;
      MX_RDIV:  mon_out = rdiv_tap;
      MX_LOCKA: mon_out = lock_ana;
      MX_SDO:   mon_out = sdo;
      MX_LOW:   mon_out = 1'b0;
      default:  mon_oe  = 1'b0;
    endcase
  end

  // R6: the released code never drives, the constant codes hold their level
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == MX_HIZ) |-> !mon_oe);
  p_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == MX_HIGH || sel == MX_LOW) |-> (mon_oe && (mon_out == (sel == MX_HIGH))));
endmodule

// File: rtl/synctl_top.sv
module synctl_top
  import synctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_load,
  input  logic        chip_en,
  input  logic        lock_dig,
  input  logic        lock_ana,
  input  logic        ndiv_tap,
  input  logic        rdiv_tap,
  output logic [13:0] r_div,
  output logic [1:0]  bl_code,
  output logic [5:0]  a_cnt,
  output logic [12:0] b_cnt,
  output logic        ld_fine,
  output logic [1:0]  psc_sel,
  output logic        pd_neg,
  output logic [2:0]  mux_sel,
  output logic        pwr_down,
  output logic        cnt_hold,
  output logic        cp_hiz,
  output logic        mon_out,
  output logic        mon_oe
);
  localparam int SYNC_STAGES = 2;
  localparam int IDX_CLK  = 0;
  localparam int IDX_DAT  = 1;
  localparam int IDX_LOAD = 2;
  localparam int NSER     = 3;

  logic [NSER-1:0]   ser_lvl, ser_rise;
  logic [WORD_W-1:0] chain, ref_q, cnt_q, fn_q;
  logic              crst, pd_eff;

  synctl_sync_edge #(.W(NSER), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_load, ser_data, ser_clk}),
    .level    (ser_lvl),
    .rise     (ser_rise)
  );

  synctl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (ser_rise[IDX_CLK]),
    .bit_in   (ser_lvl[IDX_DAT]),
    .word     (chain)
  );

  synctl_latch_bank #(.WORD_W(WORD_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (ser_rise[IDX_LOAD]),
    .word    (chain),
    .ref_q   (ref_q),
    .cnt_q   (cnt_q),
    .fn_q    (fn_q)
  );

  assign r_div   = ref_q[RDIV_LO +: RDIV_W];
  assign bl_code = ref_q[BL_LO +: BL_W];
  assign a_cnt   = cnt_q[ACNT_LO +: ACNT_W];
  assign b_cnt   = cnt_q[BCNT_LO +: BCNT_W];
  assign ld_fine = cnt_q[LDF_BIT];
  assign psc_sel = fn_q[PSC_LO +: PSC_W];
  assign pd_neg  = fn_q[POL_BIT];
  assign mux_sel = fn_q[MUX_LO +: MUX_W];
  assign crst    = fn_q[CRST_BIT];

  assign pd_eff   = fn_q[SWPD_BIT] | ~chip_en;
  assign pwr_down = pd_eff;
  assign cnt_hold = crst | pd_eff;
  assign cp_hiz   = fn_q[TRI_BIT] | crst | pd_eff;

  synctl_outmux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (mux_sel),
    .pd_eff   (pd_eff),
    .lock_dig (lock_dig),
    .lock_ana (lock_ana),
    .ndiv_tap (ndiv_tap),
    .rdiv_tap (rdiv_tap),
    .sdo      (chain[WORD_W-1]),
    .mon_out  (mon_out),
    .mon_oe   (mon_oe)
  );

  // R7: low enable forces all three controls in the same cycle
  p_ce_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (pwr_down && cp_hiz && cnt_hold));

  // R8: toggling enable alone does not disturb stored fields
  p_ce_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(chip_en) && !ser_rise[IDX_LOAD]) |=> ($stable(r_div) && $stable(b_cnt)));

  // R11: counter reset implies hold and three-state
  p_crst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    crst |-> (cnt_hold && cp_hiz));
endmodule

// File: tb/tb_synctl_top.sv
`timescale 1ns/100ps
module tb_synctl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 0, ser_data = 0, ser_load = 0, chip_en = 1;
  logic lock_dig = 0, lock_ana = 0, ndiv_tap = 0, rdiv_tap = 0;
  logic [13:0] r_div; logic [1:0] bl_code; logic [5:0] a_cnt; logic [12:0] b_cnt;
  logic ld_fine, pd_neg, pwr_down, cnt_hold, cp_hiz, mon_out, mon_oe;
  logic [1:0] psc_sel; logic [2:0] mux_sel;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench-side model of register contents
  logic [13:0] e_r; logic [1:0] e_bl; logic [5:0] e_a; logic [12:0] e_b; logic e_ldf;
  logic [1:0] e_psc; logic e_tri, e_pol, e_pd, e_crst; logic [2:0] e_mux;
  logic e_sdo;

  always #2.5 clk = ~clk;

  synctl_top dut (.*);

  function automatic logic [23:0] mk_ref(logic [13:0] r, logic [1:0] bl);
    return {6'b0, bl, r, 2'b00};
  endfunction
  function automatic logic [23:0] mk_cnt(logic ldf, logic [12:0] b, logic [5:0] a);
    return {2'b0, ldf, b, a, 2'b01};
  endfunction
  function automatic logic [23:0] mk_fn(logic [1:0] psc, logic tri_b, logic pol,
                                        logic [2:0] mx, logic pd, logic crst);
    return {psc, 13'b0, tri_b, pol, mx, pd, crst, 2'b10};
  endfunction
  function automatic logic exp_mon(logic [2:0] s, logic pdx);
    case (s)
      3'b001: return lock_dig & ~pdx;
      3'b010: return ndiv_tap;
      3'b011: return 1'b1;
      3'b100: return rdiv_tap;
      3'b101: return lock_ana;
      3'b110: return e_sdo;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
    ser_load = 1'b1;
    repeat (4) @(negedge clk);
    ser_load = 1'b0;
    repeat (6) @(negedge clk);
    e_sdo = w[23];
    case (w[1:0])
      2'b00: begin e_r = w[15:2]; e_bl = w[17:16]; end
      2'b01: begin e_a = w[7:2]; e_b = w[20:8]; e_ldf = w[21]; end
      2'b10: begin e_crst = w[2]; e_pd = w[3]; e_mux = w[6:4]; e_pol = w[7];
                   e_tri = w[8]; e_psc = w[23:22]; end
      default: ;
    endcase
  endtask

  task automatic check_all(string tag);
    logic pdx;
    pdx = e_pd | ~chip_en;
    chk({tag, " R3 r_div"}, 32'(r_div), 32'(e_r));
    chk({tag, " R3 bl_code"}, 32'(bl_code), 32'(e_bl));
    chk({tag, " R4 a_cnt"}, 32'(a_cnt), 32'(e_a));
    chk({tag, " R4 b_cnt"}, 32'(b_cnt), 32'(e_b));
    chk({tag, " R4 ld_fine"}, 32'(ld_fine), 32'(e_ldf));
    chk({tag, " R5 psc/pol/mux"}, {27'b0, psc_sel, pd_neg, mux_sel},
        {27'b0, e_psc, e_pol, e_mux});
    chk({tag, " R7 R11 pwr_down"}, 32'(pwr_down), 32'(pdx));
    chk({tag, " R11 cnt_hold"}, 32'(cnt_hold), 32'(e_crst | pdx));
    chk({tag, " R11 cp_hiz"}, 32'(cp_hiz), 32'(e_tri | e_crst | pdx));
    chk({tag, " R6 mon_oe"}, 32'(mon_oe), 32'(e_mux != 3'b000));
    chk({tag, " R6 mon_out"}, 32'(mon_out), 32'(exp_mon(e_mux, pdx)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog R2 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    e_r = 0; e_bl = 0; e_a = 0; e_b = 0; e_ldf = 0; e_psc = 0; e_tri = 0;
    e_pol = 0; e_pd = 0; e_crst = 0; e_mux = 0; e_sdo = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("reset R10");

    // directed: boundary values, MSB-first order (R1, R2)
    send(mk_ref(14'h3FFF, 2'b10)); check_all("ref max R1 R2");
    send(mk_ref(14'h0001, 2'b10)); check_all("ref min R3");
    send(mk_cnt(1'b1, 13'h1FFF, 6'h3F)); check_all("cnt max R4");
    send(mk_cnt(1'b0, 13'h0003, 6'h00)); check_all("cnt min R4");

    // R9: code 11 with all other bits set changes nothing
    send(24'hFFFFFF); check_all("ignore R9");

    // random mix
    for (int k = 0; k < 12; k++) begin
      send(mk_ref(14'($urandom), 2'($urandom)));
      send(mk_cnt(1'($urandom), 13'($urandom), 6'($urandom)));
      send(mk_fn(2'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
                 1'($urandom), 1'($urandom)));
      lock_dig = 1'($urandom); lock_ana = 1'($urandom);
      ndiv_tap = 1'($urandom); rdiv_tap = 1'($urandom);
      @(negedge clk);
      check_all("random R2 R5");
    end

    // every monitor code with both tap levels (R6)
    for (int m = 0; m < 8; m++) begin
      send(mk_fn(2'(m[1:0] ^ 2'b10), 1'b0, 1'b0, 3'(m), 1'b0, 1'b0));
      for (int v = 0; v < 2; v++) begin
        lock_dig = v[0]; lock_ana = ~v[0]; ndiv_tap = v[0]; rdiv_tap = ~v[0];
        @(negedge clk);
        check_all("mux R6");
      end
    end

    // R11: counter reset and software power-down
    send(mk_fn(2'b01, 1'b0, 1'b1, 3'b001, 1'b0, 1'b1)); check_all("crst R11");
    send(mk_fn(2'b01, 1'b0, 1'b0, 3'b001, 1'b1, 1'b0)); check_all("swpd R11");
    send(mk_fn(2'b00, 1'b1, 1'b0, 3'b011, 1'b0, 1'b0)); check_all("tri R11");

    // R7 R8: chip enable low overrides, loads continue, state survives
    send(mk_fn(2'b11, 1'b0, 1'b0, 3'b101, 1'b0, 1'b0));
    @(negedge clk); chip_en = 1'b0; @(negedge clk);
    check_all("ce low R7");
    lock_dig = 1'b1;
    send(mk_fn(2'b10, 1'b0, 1'b1, 3'b001, 1'b0, 1'b0));
    check_all("ce low load R8");
    send(mk_ref(14'h2A5C, 2'b10));
    send(mk_cnt(1'b1, 13'h0ABC, 6'h15));
    check_all("ce low ref/cnt R8");
    chip_en = 1'b1; @(negedge clk);
    check_all("ce high R8");
    chip_en = 1'b0; @(negedge clk); chip_en = 1'b1; @(negedge clk);
    check_all("ce toggle R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule